// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Address Arbitration

This block is a clocked shared memory of 2048 bytes with two independent access ports, called left and right. Each port can read or write any location, and both ports can work in the same cycle. Each port has its own select, direction and output-enable controls, all active low.

When both selected ports point at the same location, an arbiter gives the location to the port that was there first. The other port then sees an active-low busy flag. In the default (master) build, the busy flag is driven out and the losing port's write is dropped inside the block. The losing port's read register also keeps its earlier value.

In the slave build, each port's busy flag is an input instead. The block applies no arbitration of its own, and a low busy input stops that port's write. Two memories can then be placed side by side to widen the word, with one master deciding for both.

Top module: `dpram_arb`

## Requirements
- R1: A byte written through either port is stored at its 11-bit address. A later read of that address from either port returns it on the read data one clock edge after the read is presented.
- R2: A write takes effect only in a cycle where both the port's select and its direction input (0 = write, 1 = read) are low. A write attempted with the select high leaves the location unchanged.
- R3: The read data output of a port is 0 whenever that port's select or output enable is high. Otherwise it shows the port's read register.
- R4: In a cycle where a port writes, its read register takes the written byte.
- R5: When both selected ports address the same location, the port that was already selected on that address in the previous cycle keeps the location. The other port's busy output is 0 in that same cycle, and it stays 0 while the match lasts.
- R6: When both ports arrive at a shared location in the same cycle, the left port wins and the right port's busy output is 0.
- R7: A busy output returns to 1 in the cycle in which the addresses differ or either port's select goes high.
- R8: In the master build, a write from the port whose busy output is 0 is discarded.
- R9: While a port is held busy and keeps reading the same address, its read register keeps its value even if the winning port writes there. The register refreshes once busy clears, the address changes, the select toggles or the direction toggles.
- R10: In the slave build, both busy outputs stay 1 and no internal arbitration applies. A port whose busy input is 0 cannot write.
- R11: During reset, both read registers are 0. With differing addresses, both busy outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left direction, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_busy_n_i | input | 1 | Left busy input (slave build only) |
| l_busy_n_o | output | 1 | Left busy output, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right direction, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_busy_n_i | input | 1 | Right busy input (slave build only) |
| r_busy_n_o | output | 1 | Right busy output, active low |

## Verification
Several properties are checked on every cycle:
- the two busy outputs are never low together;
- a busy output is only low while both ports are selected on one address;
- the owner keeps the location for as long as the match lasts;
- a held read register does not move.

Other behaviours can only be shown by the scenarios:
- which port wins under each arrival order and under a tie;
- that a blocked write never reaches the array;
- which of the release events refreshes a stale read, and what value it returns;
- how the slave build reacts to its busy inputs.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_n_i,
  output logic          l_busy_n_o,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_n_i,
  output logic          r_busy_n_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_L    = 2'd1;
  localparam logic [1:0] OWN_R    = 2'd2;

  logic [DW-1:0] mem [DEPTH];

  logic          l_act, r_act, same_loc;
  logic          l_act_q, r_act_q, l_rd_q, r_rd_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_stay, r_stay;
  logic [1:0]    owner_q, win;
  logic          l_blk, r_blk;
  logic          l_rd, r_rd, l_wr, r_wr, l_hold, r_hold;
  logic [DW-1:0] l_q, r_q;

  assign l_act    = !l_cs_n;
  assign r_act    = !r_cs_n;
  assign same_loc = l_act && r_act && (l_addr == r_addr);
  assign l_stay   = l_act_q && (l_addr_q == l_addr);
  assign r_stay   = r_act_q && (r_addr_q == r_addr);

  always_comb begin
    win = OWN_NONE;
    if (same_loc) begin
      if (owner_q != OWN_NONE)    win = owner_q;
      else if (r_stay && !l_stay) win = OWN_R;
      else                        win = OWN_L;
    end
  end

  assign l_busy_n_o = IS_SLAVE ? 1'b1 : (win != OWN_R);
  assign r_busy_n_o = IS_SLAVE ? 1'b1 : (win != OWN_L);
  assign l_blk      = IS_SLAVE ? !l_busy_n_i : (win == OWN_R);
  assign r_blk      = IS_SLAVE ? !r_busy_n_i : (win == OWN_L);

  assign l_rd   = l_act && l_we_n;
  assign r_rd   = r_act && r_we_n;
  assign l_wr   = l_act && !l_we_n && !l_blk;
  assign r_wr   = r_act && !r_we_n && !r_blk;
  assign l_hold = l_blk && l_rd && l_rd_q && (l_addr == l_addr_q);
  assign r_hold = r_blk && r_rd && r_rd_q && (r_addr == r_addr_q);

  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_act_q  <= 1'b0;
      r_act_q  <= 1'b0;
      l_rd_q   <= 1'b0;
      r_rd_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q  <= win;
      l_act_q  <= l_act;
      r_act_q  <= r_act;
      l_rd_q   <= l_rd;
      r_rd_q   <= r_rd;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                l_q <= '0;
    else if (l_wr)             l_q <= l_wdata;
    else if (l_rd && !l_hold)  l_q <= mem[l_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                r_q <= '0;
    else if (r_wr)             r_q <= r_wdata;
    else if (r_rd && !r_hold)  r_q <= mem[r_addr];
  end

  assign l_rdata = (l_act && !l_oe_n) ? l_q : '0;
  assign r_rdata = (r_act && !r_oe_n) ? r_q : '0;

  // R9
  l_stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_hold |=> (l_q == $past(l_q)));
  // R9
  r_stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_hold |=> (r_q == $past(r_q)));

  generate
    if (!IS_SLAVE) begin : g_master_chk
      // R5
      busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n_o && !r_busy_n_o));
      // R7
      busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n_o || !r_busy_n_o) |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr)));
      // R5
      r_keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n_o |=> (!(!l_cs_n && !r_cs_n && (l_addr == r_addr)) || !r_busy_n_o));
      // R5
      l_keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n_o |=> (!(!l_cs_n && !r_cs_n && (l_addr == r_addr)) || !l_busy_n_o));
    end
  endgenerate
endmodule

// File: tb/sim_dpram_arb.sv
module sim_dpram_arb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  req;
    logic        lc, lw, lo;
    logic [10:0] la;
    logic [7:0]  ld;
    logic        rc, rw, ro;
    logic [10:0] ra;
    logic [7:0]  rd;
    logic        elb, erb;
    logic [7:0]  elq, erq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0,1'b0,1'b0, 11'h010, 8'hA5, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b1,1'b1, 8'hA5, 8'h00}, // R1 R4
    '{4'd1, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b0,1'b1,1'b0, 11'h010, 8'h00, 1'b1,1'b1, 8'h00, 8'hA5}, // R1
    '{4'd1, 1'b0,1'b1,1'b0, 11'h010, 8'h00, 1'b0,1'b0,1'b0, 11'h7FF, 8'h3C, 1'b1,1'b1, 8'hA5, 8'h3C}, // R1
    '{4'd3, 1'b0,1'b1,1'b1, 11'h7FF, 8'h00, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b1,1'b1, 8'h00, 8'h00}, // R3
    '{4'd3, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b1,1'b1, 8'h3C, 8'h00}, // R3
    '{4'd2, 1'b1,1'b0,1'b0, 11'h010, 8'hFF, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b1,1'b1, 8'h00, 8'h00}, // R2
    '{4'd2, 1'b0,1'b1,1'b0, 11'h010, 8'h00, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b1, 8'hA5, 8'h3C}, // R2
    '{4'd4, 1'b0,1'b0,1'b0, 11'h020, 8'h11, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b1, 8'h11, 8'h3C}, // R4
    '{4'd5, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b0,1'b0, 11'h020, 8'h22, 1'b1,1'b0, 8'h11, 8'h3C}, // R5
    '{4'd8, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b1,1'b0, 11'h000, 8'h00, 1'b1,1'b1, 8'h11, 8'h00}, // R8
    '{4'd5, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b0, 8'h11, 8'h11}, // R5
    '{4'd9, 1'b0,1'b0,1'b0, 11'h020, 8'h77, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b0, 8'h77, 8'h11}, // R9
    '{4'd9, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b0, 8'h77, 8'h11}, // R9
    '{4'd7, 1'b1,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b1, 8'h00, 8'h77}, // R7 R9
    '{4'd5, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b0,1'b1, 8'h77, 8'h77}, // R5
    '{4'd7, 1'b0,1'b1,1'b0, 11'h010, 8'h00, 1'b0,1'b1,1'b0, 11'h020, 8'h00, 1'b1,1'b1, 8'hA5, 8'h77}, // R7
    '{4'd6, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b0, 8'h3C, 8'h3C}, // R6
    '{4'd9, 1'b0,1'b0,1'b0, 11'h7FF, 8'h5A, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b0, 8'h5A, 8'h3C}, // R9
    '{4'd8, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b0,1'b0,1'b0, 11'h7FF, 8'h99, 1'b1,1'b0, 8'h5A, 8'h3C}, // R8
    '{4'd9, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b1,1'b0, 8'h5A, 8'h5A}, // R9 R8
    '{4'd7, 1'b0,1'b1,1'b0, 11'h7FF, 8'h00, 1'b0,1'b1,1'b0, 11'h010, 8'h00, 1'b1,1'b1, 8'h5A, 8'hA5}  // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic l_cs_n, l_we_n, l_oe_n, r_cs_n, r_we_n, r_oe_n;
  logic [10:0] l_addr, r_addr;
  logic [7:0]  l_wdata, r_wdata, l_rdata, r_rdata;
  logic        l_busy_n_o, r_busy_n_o;

  logic s_l_cs_n, s_l_we_n, s_l_oe_n, s_r_cs_n, s_r_we_n, s_r_oe_n;
  logic [10:0] s_l_addr, s_r_addr;
  logic [7:0]  s_l_wdata, s_r_wdata, s_l_rdata, s_r_rdata;
  logic        s_l_bi, s_r_bi, s_l_bo, s_r_bo;

  dpram_arb u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_n_i(1'b1), .l_busy_n_o(l_busy_n_o),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_n_i(1'b1), .r_busy_n_o(r_busy_n_o)
  );

  dpram_arb #(.IS_SLAVE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(s_l_cs_n), .l_we_n(s_l_we_n), .l_oe_n(s_l_oe_n), .l_addr(s_l_addr),
    .l_wdata(s_l_wdata), .l_rdata(s_l_rdata), .l_busy_n_i(s_l_bi), .l_busy_n_o(s_l_bo),
    .r_cs_n(s_r_cs_n), .r_we_n(s_r_we_n), .r_oe_n(s_r_oe_n), .r_addr(s_r_addr),
    .r_wdata(s_r_wdata), .r_rdata(s_r_rdata), .r_busy_n_i(s_r_bi), .r_busy_n_o(s_r_bo)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    l_cs_n = 1'b0; l_we_n = 1'b1; l_oe_n = 1'b0; l_addr = 11'h001; l_wdata = '0;
    r_cs_n = 1'b0; r_we_n = 1'b1; r_oe_n = 1'b0; r_addr = 11'h002; r_wdata = '0;
    s_l_cs_n = 1'b0; s_l_we_n = 1'b1; s_l_oe_n = 1'b0; s_l_addr = 11'h001; s_l_wdata = '0;
    s_r_cs_n = 1'b0; s_r_we_n = 1'b1; s_r_oe_n = 1'b0; s_r_addr = 11'h002; s_r_wdata = '0;
    s_l_bi = 1'b1; s_r_bi = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state of both builds
    chk("R11", "u0 l_rdata", {24'd0, l_rdata}, 32'h0);
    chk("R11", "u0 r_rdata", {24'd0, r_rdata}, 32'h0);
    chk("R11", "u0 l_busy", {31'd0, l_busy_n_o}, 32'h1);
    chk("R11", "u0 r_busy", {31'd0, r_busy_n_o}, 32'h1);
    chk("R11", "u1 l_rdata", {24'd0, s_l_rdata}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    s_l_cs_n = 1'b1; s_r_cs_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      l_cs_n = TBL[i].lc; l_we_n = TBL[i].lw; l_oe_n = TBL[i].lo;
      l_addr = TBL[i].la; l_wdata = TBL[i].ld;
      r_cs_n = TBL[i].rc; r_we_n = TBL[i].rw; r_oe_n = TBL[i].ro;
      r_addr = TBL[i].ra; r_wdata = TBL[i].rd;
      #1;
      chk(tag, "l_busy", {31'd0, l_busy_n_o}, {31'd0, TBL[i].elb});
      chk(tag, "r_busy", {31'd0, r_busy_n_o}, {31'd0, TBL[i].erb});
      @(posedge clk);
      #1;
      chk(tag, "l_rdata", {24'd0, l_rdata}, {24'd0, TBL[i].elq});
      chk(tag, "r_rdata", {24'd0, r_rdata}, {24'd0, TBL[i].erq});
      @(negedge clk);
    end
    l_cs_n = 1'b1; r_cs_n = 1'b1;

    // R10: slave build, left writes 040 = 12 with busy input high
    s_l_cs_n = 1'b0; s_l_we_n = 1'b0; s_l_addr = 11'h040; s_l_wdata = 8'h12;
    s_r_cs_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", "u1 l_rdata after write", {24'd0, s_l_rdata}, 32'h12);
    @(negedge clk);
    // R10: left write with busy input low while right reads the same location
    s_l_wdata = 8'hEE; s_l_bi = 1'b0;
    s_r_cs_n = 1'b0; s_r_we_n = 1'b1; s_r_addr = 11'h040;
    #1;
    chk("R10", "u1 l_busy stays high on match", {31'd0, s_l_bo}, 32'h1);
    chk("R10", "u1 r_busy stays high on match", {31'd0, s_r_bo}, 32'h1);
    @(posedge clk); #1;
    chk("R10", "u1 blocked write keeps l_rdata", {24'd0, s_l_rdata}, 32'h12);
    chk("R10", "u1 r_rdata", {24'd0, s_r_rdata}, 32'h12);
    @(negedge clk);
    s_l_bi = 1'b1; s_l_we_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", "u1 blocked write discarded (left)", {24'd0, s_l_rdata}, 32'h12);
    chk("R10", "u1 blocked write discarded (right)", {24'd0, s_r_rdata}, 32'h12);
    @(negedge clk);
    finish_run();
  end
endmodule